// File: doc/BRIEF.md
# Slave FIFO Packet-End Write Controller

This block is the FPGA-side master of a synchronous slave FIFO link into a USB bridge chip. It sends a stream of known length, in 32-bit words, into the bridge. A length command comes in while the block is idle. Data words then arrive on a valid/ready port and are written across the link using active-low chip-select and write strobes. The block throttles itself on two active-low flags from the bridge. The buffer-ready flag gates every write. The watermark flag marks the point where the buffer is nearly full.

How a transfer ends depends on its length. A length that is not a whole number of USB packets (PKT_WORDS words, 256 by default, which is 1024 bytes) ends with packet-end asserted together with the last word. An exact multiple ends with the last word written plain. After it comes a fixed gap, then a re-check of buffer-ready, then a one-cycle zero-length-packet strobe and a second gap. An optional mode removes the zero-length packet: packet-end is raised on the second-to-last word and again on the last word, so the final full packet leaves as two short packets.

Top module: `sfifo_pktend_wr`

## Requirements
- R1: While reset is held and right after it is released, chip-select, write strobe and packet-end are all high, `done_o` is low and `len_ready_o` is high.
- R2: A word is written by driving `slcs_no` and `slwr_no` low in the same cycle, with `fifo_dat_o` carrying the source word. That same cycle is the valid/ready handshake: `dat_ready_o` is high exactly when a word is written.
- R3: A length that is not a multiple of PKT_WORDS ends with `pktend_no` low in the cycle that writes the last word. No zero-length packet follows, and `done_o` pulses in the next cycle.
- R4: A length that is a nonzero multiple of PKT_WORDS, with split mode off, writes its last word with `pktend_no` high. The block then waits GAP_CYC idle cycles and then waits for `flag_rdy_ni` to be low. In the first cycle where it is low, the block drives a zero-length-packet strobe for exactly one cycle: `slcs_no` low, `pktend_no` low, `slwr_no` high.
- R5: After the zero-length-packet strobe, the block holds all strobes high for GAP_CYC cycles and then pulses `done_o`.
- R6: No word and no zero-length-packet strobe is issued in a cycle where `flag_rdy_ni` is high. No word is issued in a cycle where `dat_valid_i` is low.
- R7: While `flag_wm_ni` is low, words are written on consecutive cycles. A word written while `flag_wm_ni` is high (and not the last word) is followed by exactly SETTLE_CYC cycles with no write.
- R8: With `nozlp_i` set at acceptance and a length that is a multiple of PKT_WORDS, `pktend_no` is low with the second-to-last word and with the last word. No zero-length packet is sent, and `done_o` pulses in the cycle after the last word.
- R9: `done_o` is high for exactly one cycle per accepted length.
- R10: `len_ready_o` is high only while idle. A `len_valid_i` pulse seen while a transfer runs is ignored and has no effect on the strobes.
- R11: A length of zero is accepted and completes with a `done_o` pulse in the next cycle, without any strobe.
- R12: `fifo_addr_o` holds the value of `fifo_addr_i` captured when the length was accepted, for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| len_valid_i | input | 1 | Length command valid |
| len_words_i | input | LEN_W | Transfer length in 32-bit words |
| nozlp_i | input | 1 | Split the last full packet instead of sending a zero-length packet |
| fifo_addr_i | input | 2 | Bridge FIFO address to use for the transfer |
| len_ready_o | output | 1 | Idle; a length is taken in this cycle if valid |
| dat_valid_i | input | 1 | Source word valid |
| dat_i | input | DATA_W | Source word |
| dat_ready_o | output | 1 | Source word consumed this cycle |
| flag_rdy_ni | input | 1 | Bridge buffer ready, active low |
| flag_wm_ni | input | 1 | Bridge watermark (ample space), active low |
| slcs_no | output | 1 | Chip select, active low |
| slwr_no | output | 1 | Write strobe, active low |
| pktend_no | output | 1 | Packet end, active low |
| fifo_addr_o | output | 2 | Bridge FIFO address |
| fifo_dat_o | output | DATA_W | Bridge data bus |
| done_o | output | 1 | One-cycle transfer completion pulse |

## Verification
The bench builds the block with PKT_WORDS=16, SETTLE_CYC=2 and GAP_CYC=4. With 16-word packets, lengths of one, two and three full packets, and lengths on either side of them, finish in a few hundred cycles. Every ending appears several times: short packet, delayed zero-length packet, and split pair. The short settle window lets the random watermark and ready patterns fall into settle and zero-length waits often, including a ready flag held off during the zero-length wait.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_SETTLE,
    ST_GAP_PRE,
    ST_ZWAIT,
    ST_GAP_POST,
    ST_DONE
  } wr_state_e;
endpackage

// File: rtl/sfifo_len_class.sv
module sfifo_len_class #(
  parameter int LEN_W     = 16,
  parameter int PKT_WORDS = 256
) (
  input  logic [LEN_W-1:0] len_i,
  output logic             is_zero_o,
  output logic             is_mult_o
);
  localparam int PKT_LOG = $clog2(PKT_WORDS);

  generate
    if ((1 << PKT_LOG) == PKT_WORDS) begin : g_pow2
      assign is_mult_o = (len_i[PKT_LOG-1:0] == '0) && (len_i != '0);
    end else begin : g_mod
      assign is_mult_o = ((32'(len_i) % PKT_WORDS) == 0) && (len_i != '0);
    end
  endgenerate

  assign is_zero_o = (len_i == '0);
endmodule

// File: rtl/sfifo_word_ctr.sv
module sfifo_word_ctr #(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             split_en_i,
  output logic             is_last_o,
  output logic             is_split_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + LEN_W'(1);
  end

  assign is_last_o  = (cnt_q == len_i - LEN_W'(1));
  assign is_split_o = split_en_i && (cnt_q == len_i - LEN_W'(2));
endmodule

// File: rtl/sfifo_wait_tmr.sv
module sfifo_wait_tmr #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sfifo_pktend_wr.sv
module sfifo_pktend_wr
  import sfifo_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int PKT_WORDS  = 256,
  parameter int SETTLE_CYC = 3,
  parameter int GAP_CYC    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              len_valid_i,
  input  logic [LEN_W-1:0]  len_words_i,
  input  logic              nozlp_i,
  input  logic [1:0]        fifo_addr_i,
  output logic              len_ready_o,
  input  logic              dat_valid_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic              dat_ready_o,
  input  logic              flag_rdy_ni,
  input  logic              flag_wm_ni,
  output logic              slcs_no,
  output logic              slwr_no,
  output logic              pktend_no,
  output logic [1:0]        fifo_addr_o,
  output logic [DATA_W-1:0] fifo_dat_o,
  output logic              done_o
);
  localparam int TMR_MAX = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  wr_state_e        state_q, state_d;
  logic [LEN_W-1:0] len_q;
  logic             mult_q, nozlp_q;
  logic [1:0]       addr_q;

  logic in_zero, in_mult;
  logic is_last, is_split;
  logic fire, zlp, accept;
  logic tmr_load, tmr_tick, tmr_exp;
  logic [TMR_W-1:0] tmr_val;

  sfifo_len_class #(.LEN_W(LEN_W), .PKT_WORDS(PKT_WORDS)) u_class (
    .len_i     (len_words_i),
    .is_zero_o (in_zero),
    .is_mult_o (in_mult)
  );

  sfifo_word_ctr #(.LEN_W(LEN_W)) u_words (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (accept),
    .inc_i      (fire),
    .len_i      (len_q),
    .split_en_i (mult_q && nozlp_q),
    .is_last_o  (is_last),
    .is_split_o (is_split)
  );

  sfifo_wait_tmr #(.CNT_W(TMR_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .tick_i     (tmr_tick),
    .expired_o  (tmr_exp)
  );

  assign accept   = (state_q == ST_IDLE) && len_valid_i;
  assign fire     = (state_q == ST_WRITE) && dat_valid_i && !flag_rdy_ni;
  assign zlp      = (state_q == ST_ZWAIT) && !flag_rdy_ni;
  assign tmr_tick = (state_q == ST_SETTLE) || (state_q == ST_GAP_PRE) ||
                    (state_q == ST_GAP_POST);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(GAP_CYC - 1);
    unique case (state_q)
      ST_IDLE: if (len_valid_i) state_d = in_zero ? ST_DONE : ST_WRITE;
      ST_WRITE: begin
        if (fire) begin
          if (is_last) begin
            if (mult_q && !nozlp_q) begin
              state_d  = ST_GAP_PRE;
              tmr_load = 1'b1;
            end else begin
              state_d = ST_DONE;
            end
          end else if (flag_wm_ni) begin
            // nearly full: one word, then let the ready flag settle
            state_d  = ST_SETTLE;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(SETTLE_CYC - 1);
          end
        end
      end
      ST_SETTLE:   if (tmr_exp) state_d = ST_WRITE;
      ST_GAP_PRE:  if (tmr_exp) state_d = ST_ZWAIT;
      ST_ZWAIT: begin
        if (zlp) begin
          state_d  = ST_GAP_POST;
          tmr_load = 1'b1;
        end
      end
      ST_GAP_POST: if (tmr_exp) state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      mult_q  <= 1'b0;
      nozlp_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        len_q   <= len_words_i;
        mult_q  <= in_mult;
        nozlp_q <= nozlp_i;
        addr_q  <= fifo_addr_i;
      end
    end
  end

  assign slcs_no     = !(fire || zlp);
  assign slwr_no     = !fire;
  assign pktend_no   = !(zlp || (fire && ((is_last && (!mult_q || nozlp_q)) || is_split)));
  assign dat_ready_o = fire;
  assign fifo_dat_o  = dat_i;
  assign fifo_addr_o = addr_q;
  assign len_ready_o = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
endmodule

// File: rtl/sfifo_pktend_wr_chk.sv
module sfifo_pktend_wr_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic len_valid_i,
  input logic len_ready_o,
  input logic dat_valid_i,
  input logic dat_ready_o,
  input logic flag_rdy_ni,
  input logic slcs_no,
  input logic slwr_no,
  input logic pktend_no,
  input logic done_o
);
  assert_write_pair_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slwr_no |-> (!slcs_no && dat_ready_o));

  assert_write_needs_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slcs_no |-> !flag_rdy_ni);

  assert_write_needs_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slwr_no |-> dat_valid_i);

  assert_zlp_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slcs_no && slwr_no && !pktend_no) |=> slcs_no);

  assert_pktend_with_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pktend_no |-> !slcs_no);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_idle_no_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_ready_o |-> (slcs_no && !done_o));
endmodule

bind sfifo_pktend_wr sfifo_pktend_wr_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .len_valid_i (len_valid_i),
  .len_ready_o (len_ready_o),
  .dat_valid_i (dat_valid_i),
  .dat_ready_o (dat_ready_o),
  .flag_rdy_ni (flag_rdy_ni),
  .slcs_no     (slcs_no),
  .slwr_no     (slwr_no),
  .pktend_no   (pktend_no),
  .done_o      (done_o)
);

// File: tb/sfifo_pktend_wr_bench.sv
`timescale 1ns/1ps
module sfifo_pktend_wr_bench;
  localparam int DW  = 32;
  localparam int LW  = 16;
  localparam int PKT = 16;
  localparam int SET = 2;
  localparam int GAP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          len_valid = 1'b0;
  logic [LW-1:0] len_words = '0;
  logic          nozlp = 1'b0;
  logic [1:0]    addr_cfg = 2'd0;
  logic          dat_valid = 1'b0;
  logic [DW-1:0] dat = '0;
  logic          rdy_n = 1'b1;
  logic          wm_n = 1'b1;
  logic len_ready, dat_ready, slcs_n, slwr_n, pktend_n, done;
  logic [1:0]    addr_o;
  logic [DW-1:0] dat_o;

  sfifo_pktend_wr #(.DATA_W(DW), .LEN_W(LW), .PKT_WORDS(PKT),
                    .SETTLE_CYC(SET), .GAP_CYC(GAP)) u_sfifo_pktend_wr (
    .clk_i(clk), .rst_ni(rst_n), .len_valid_i(len_valid), .len_words_i(len_words),
    .nozlp_i(nozlp), .fifo_addr_i(addr_cfg), .len_ready_o(len_ready),
    .dat_valid_i(dat_valid), .dat_i(dat), .dat_ready_o(dat_ready),
    .flag_rdy_ni(rdy_n), .flag_wm_ni(wm_n), .slcs_no(slcs_n), .slwr_no(slwr_n),
    .pktend_no(pktend_n), .fifo_addr_o(addr_o), .fifo_dat_o(dat_o), .done_o(done));

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural reference: phase 0 idle,1 write,2 settle,3 pre-gap,4 zlp wait,5 post-gap,6 done
  int m_ph, m_len, m_sent, m_cnt;
  bit m_mult, m_nz;
  logic [1:0] m_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_len <= 0; m_sent <= 0; m_cnt <= 0;
      m_mult <= 0; m_nz <= 0; m_addr <= 2'd0;
    end else begin
      case (m_ph)
        0: if (len_valid) begin
          m_len  <= int'(len_words);
          m_nz   <= nozlp;
          m_addr <= addr_cfg;
          m_mult <= (len_words != 0) && (int'(len_words) % PKT == 0);
          m_sent <= 0;
          m_ph   <= (len_words == 0) ? 6 : 1;
        end
        1: if (dat_valid && !rdy_n) begin
          m_sent <= m_sent + 1;
          if (m_sent == m_len - 1) begin
            m_ph  <= (m_mult && !m_nz) ? 3 : 6;
            m_cnt <= GAP;
          end else if (wm_n) begin
            m_ph  <= 2;
            m_cnt <= SET;
          end
        end
        2: if (m_cnt == 1) m_ph <= 1; else m_cnt <= m_cnt - 1;
        3: if (m_cnt == 1) m_ph <= 4; else m_cnt <= m_cnt - 1;
        4: if (!rdy_n) begin m_ph <= 5; m_cnt <= GAP; end
        5: if (m_cnt == 1) m_ph <= 6; else m_cnt <= m_cnt - 1;
        default: m_ph <= 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  logic [15:0] lf = 16'hACE1;
  int pat = 0;
  int ph_at_drive = 0;
  int zw_hold = 0;
  int s_wr, s_zlp, s_pend_wr, s_done;

  // drive at negedge, compare 2 ns later, model advances at posedge
  task automatic step();
    bit e_fire, e_zlp, e_pend;
    string tag;
    @(negedge clk);
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    dat = 32'hC0DE_0000 + DW'(m_sent);
    case (pat)
      0: begin dat_valid = 1; rdy_n = 0; wm_n = 0; end
      1: begin dat_valid = 1; rdy_n = 0; wm_n = 1; end
      2: begin dat_valid = lf[0] | lf[1]; rdy_n = lf[2] & lf[3]; wm_n = lf[4] & lf[5] & lf[6]; end
      default: begin
        dat_valid = 1; wm_n = 0;
        if (m_ph == 4 && zw_hold > 0) begin rdy_n = 1; zw_hold--; end
        else rdy_n = 0;
      end
    endcase
    if (m_ph >= 1 && m_ph <= 5) begin
      len_valid = lf[7];           // R10: ignored while busy
      len_words = LW'(lf);
      addr_cfg  = lf[9:8];         // R12: must not reach fifo_addr_o
      nozlp     = lf[10];
    end
    #2;
    e_fire = (m_ph == 1) && dat_valid && !rdy_n;
    e_zlp  = (m_ph == 4) && !rdy_n;
    e_pend = e_zlp || (e_fire && (((m_sent == m_len - 1) && (!m_mult || m_nz)) ||
                                  (m_mult && m_nz && m_sent == m_len - 2)));
    case (m_ph)
      0: tag = "R10";
      1: tag = (m_sent == m_len - 1) ? (m_mult ? (m_nz ? "R8" : "R4") : "R3") : "R2";
      2: tag = "R7";
      3, 4: tag = "R4";
      5: tag = "R5";
      default: tag = "R9";
    endcase
    chk(slcs_n == !(e_fire || e_zlp), tag, "slcs_n", slcs_n, !(e_fire || e_zlp));
    chk(slwr_n == !e_fire, (m_ph == 1 && !e_fire) ? "R6" : tag, "slwr_n", slwr_n, !e_fire);
    chk(pktend_n == !e_pend, tag, "pktend_n", pktend_n, !e_pend);
    chk(dat_ready == e_fire, "R2", "dat_ready", dat_ready, e_fire);
    chk(done == (m_ph == 6), "R9", "done", done, m_ph == 6);
    chk(len_ready == (m_ph == 0), "R10", "len_ready", len_ready, m_ph == 0);
    chk(addr_o == m_addr, "R12", "fifo_addr", addr_o, m_addr);
    if (e_fire) chk(dat_o == dat, "R2", "fifo_dat", dat_o, dat);
    if (!slwr_n) s_wr++;
    if (!slcs_n && slwr_n && !pktend_n) s_zlp++;
    if (!slwr_n && !pktend_n) s_pend_wr++;
    if (done) s_done++;
  endtask

  task automatic run(input int len, input bit nz, input int p, input logic [1:0] a);
    int e_zlp, e_pw, guard;
    s_wr = 0; s_zlp = 0; s_pend_wr = 0; s_done = 0;
    pat = p; zw_hold = 9;
    @(negedge clk);
    len_valid = 1; len_words = LW'(len); nozlp = nz; addr_cfg = a;
    dat_valid = 0; rdy_n = 1;
    #2;
    chk(len_ready == 1, "R10", "len_ready idle", len_ready, 1);
    guard = 0;
    step();
    len_valid = 0;
    while (m_ph != 0 && guard < 5000) begin
      step();
      len_valid = 0;
      guard++;
    end
    chk(guard < 5000, "R9", "transfer hung", guard, 0);
    e_zlp = (len > 0 && len % PKT == 0 && !nz) ? 1 : 0;
    e_pw  = (len == 0) ? 0 : (len % PKT != 0) ? 1 : (nz ? 2 : 0);
    chk(s_wr == len, (len == 0) ? "R11" : "R2", "word count", s_wr, len);
    chk(s_zlp == e_zlp, nz ? "R8" : "R4", "zlp count", s_zlp, e_zlp);
    chk(s_pend_wr == e_pw, nz ? "R8" : "R3", "pktend-with-word count", s_pend_wr, e_pw);
    chk(s_done == 1, (len == 0) ? "R11" : "R9", "done pulses", s_done, 1);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(slcs_n && slwr_n && pktend_n, "R1", "strobes in reset",
        {slcs_n, slwr_n, pktend_n}, 3'b111);
    chk(!done && len_ready, "R1", "done/len_ready in reset", {done, len_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    chk(slcs_n && slwr_n && pktend_n && !done && len_ready, "R1", "after reset",
        {slcs_n, slwr_n, pktend_n, done, len_ready}, 5'b11101);

    run(5,   0, 0, 2'd1);   // R3 short
    run(16,  0, 0, 2'd3);   // R4 one packet, delayed zlp
    run(32,  0, 2, 2'd2);   // R4/R6 random flags
    run(16,  1, 0, 2'd0);   // R8 split
    run(48,  1, 2, 2'd1);   // R8 random
    run(0,   0, 0, 2'd2);   // R11
    run(20,  0, 1, 2'd3);   // R7 singles with settle
    run(37,  0, 2, 2'd0);
    run(64,  0, 1, 2'd1);   // R7 + R4
    run(1,   0, 0, 2'd2);   // R3 single word
    run(16,  0, 3, 2'd3);   // R4 ready held off during zlp wait
    run(17,  1, 2, 2'd0);   // R3 with split flag on non-multiple
    run(0,   1, 2, 2'd1);   // R11 again
    run(48,  0, 3, 2'd2);   // R5
    for (int k = 0; k < 12; k++) run(3 + k * 7, k[0], 2, k[1:0]);
    repeat (4) step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule